// File: doc/BRIEF.md
# Queue Status Interrupt Selector

This block turns the status of 32 hardware queues into a single interrupt request. Each queue reports a 4-bit status nibble. The bits are, from bit 0 upward: empty, nearly empty, nearly full and full. Software gives each queue a 3-bit source code. The code picks one bit of the nibble and can invert it, so a queue can raise an interrupt on "full" or on "not full", and likewise for the other three flags.

A per-queue enable mask gates the chosen condition. When an enabled condition becomes true, the queue's bit in a pending bitmap is set. Software clears pending bits by writing ones to a clear address. The interrupt request is high whenever any pending bit is set.

Registers are written through a simple write-only bus:

- Addresses 0 to 3 hold the source codes, eight queues per word.
- Address 4 holds the enable mask.
- Address 5 is the write-one-to-clear port for pending bits.

Top module: `qstat_irq_sel`

## Requirements
- R1: After synchronous reset, `pending` is zero, `irq` is low, all enable bits are zero and every source code is 0.
- R2: The status nibble bits are: bit 0 empty, bit 1 nearly empty, bit 2 nearly full, bit 3 full. Source code bits [1:0] pick the nibble bit to test, and code bit 2 inverts it. Codes 0..7 therefore mean empty, nearly empty, nearly full, full, not empty, not nearly empty, not nearly full and not full.
- R3: Queue n takes its source code from the word at address n/8, at bits (n mod 8)*4 up to (n mod 8)*4+2. The fourth bit of each field is reserved and is ignored.
- R4: Bit n of the word at address 4 enables queue n. A disabled queue never sets its pending bit.
- R5: A pending bit is set one clock after the enabled, selected condition of its queue goes from false to true. This includes the case where the queue is enabled while its condition is already true.
- R6: A condition that stays true does not set its pending bit again after software has cleared it. A new false-to-true change does set it again.
- R7: A write to address 5 clears each pending bit whose data bit is 1 and leaves the others unchanged. Writing all ones clears every pending bit.
- R8: When a clear write and a new set event hit the same pending bit in the same cycle, the bit ends up set.
- R9: A write to address 4 that turns a queue's enable from 1 to 0 clears that queue's pending bit in the same update. This holds even if a set event for that queue occurs in the same cycle.
- R10: `irq` is high in exactly those cycles in which at least one pending bit is set.
- R11: Writes to addresses 6 and 7 change neither the pending bits, nor the enables, nor the source codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address |
| wr_data | input | 32 | Register write data |
| q_status | input | 128 | Status nibbles, queue n at bits 4n+3..4n |
| pending | output | 32 | Pending interrupt bitmap, one bit per queue |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `q_status` and the bus inputs are stable around the rising clock edge. They also assume that the only way a pending bit falls is through a clear or disable write, so a pending bit may only rise on a cycle that follows an enabled, true condition.

The bench drives every input on the falling edge. It changes status nibbles only between edges, and pairs a status change with a register write only in the cases that test set-versus-clear and set-versus-disable ordering.

// File: rtl/qsel_pkg.sv
package qsel_pkg;

    // Position of each flag inside a queue status nibble
    typedef enum logic [1:0] {
        FLAG_EMPTY        = 2'd0,
        FLAG_NEARLY_EMPTY = 2'd1,
        FLAG_NEARLY_FULL  = 2'd2,
        FLAG_FULL         = 2'd3
    } flag_idx_t;

    // Per-queue interrupt source code: top bit inverts the chosen flag
    typedef struct packed {
        logic      inv;
        flag_idx_t flag;
    } src_sel_t;

    localparam int unsigned SEL_W = $bits(src_sel_t);
    localparam int unsigned NIB_W = 4;

    // Evaluate the selected condition for one queue
    function automatic logic eval_cond(input logic [NIB_W-1:0] nib, input src_sel_t s);
        return nib[s.flag] ^ s.inv;
    endfunction

endpackage

// File: rtl/qsel_regs.sv
module qsel_regs
    import qsel_pkg::*;
#(
    parameter int unsigned NUM_Q   = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 3,
    parameter int unsigned FIELD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output src_sel_t          sel_o [NUM_Q],
    output logic [NUM_Q-1:0]  en_o,
    output logic [NUM_Q-1:0]  clr_mask_o,
    output logic [NUM_Q-1:0]  drop_mask_o
);
    localparam int unsigned PER_REG = DATA_W / FIELD_W;
    localparam int unsigned NREG    = NUM_Q / PER_REG;
    localparam int unsigned ADR_EN  = NREG;
    localparam int unsigned ADR_CLR = NREG + 1;

    logic              en_wr;
    logic              clr_wr;
    logic [NUM_Q-1:0]  en_q;
    logic [NUM_Q-1:0]  wr_bits;
    logic              unused_data;

    assign wr_bits     = wr_data[NUM_Q-1:0];
    assign unused_data = ^wr_data;
    assign en_wr       = wr_en && (wr_addr == ADDR_W'(ADR_EN));
    assign clr_wr      = wr_en && (wr_addr == ADDR_W'(ADR_CLR));

    // Source code fields: one register per queue, reserved bit not stored
    for (genvar q = 0; q < NUM_Q; q++) begin : g_src
        localparam int unsigned REG_IDX = q / PER_REG;
        localparam int unsigned OFF     = (q % PER_REG) * FIELD_W;
        src_sel_t sel_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(REG_IDX))) begin
                sel_q <= src_sel_t'(wr_data[OFF +: SEL_W]);
            end
        end
        assign sel_o[q] = sel_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= wr_bits;
        end
    end

    assign en_o        = en_q;
    assign clr_mask_o  = clr_wr ? wr_bits : '0;
    assign drop_mask_o = en_wr ? (en_q & ~wr_bits) : '0;

endmodule

// File: rtl/qsel_cond.sv
module qsel_cond
    import qsel_pkg::*;
#(
    parameter int unsigned NUM_Q = 32
) (
    input  logic [NUM_Q*NIB_W-1:0] q_status,
    input  src_sel_t               sel [NUM_Q],
    input  logic [NUM_Q-1:0]       en,
    output logic [NUM_Q-1:0]       gated_o
);
    for (genvar q = 0; q < NUM_Q; q++) begin : g_q
        logic hit;
        assign hit        = eval_cond(q_status[q*NIB_W +: NIB_W], sel[q]);
        assign gated_o[q] = hit & en[q];
    end
endmodule

// File: rtl/qsel_pend.sv
module qsel_pend #(
    parameter int unsigned NUM_Q = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NUM_Q-1:0] gated,
    input  logic [NUM_Q-1:0] clr_mask,
    input  logic [NUM_Q-1:0] drop_mask,
    output logic [NUM_Q-1:0] pend_o
);
    logic [NUM_Q-1:0] prev_q;
    logic [NUM_Q-1:0] pend_q;
    logic [NUM_Q-1:0] set_ev;
    logic [NUM_Q-1:0] pend_d;

    always_comb begin
        set_ev = gated & ~prev_q;
        // set beats clear; disable beats both
        pend_d = ((pend_q & ~clr_mask) | set_ev) & ~drop_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= gated;
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/qstat_irq_sel.sv
module qstat_irq_sel
    import qsel_pkg::*;
#(
    parameter int unsigned NUM_Q   = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 3,
    parameter int unsigned FIELD_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [NUM_Q*NIB_W-1:0] q_status,
    output logic [NUM_Q-1:0]       pending,
    output logic                   irq
);
    src_sel_t         sel_w [NUM_Q];
    logic [NUM_Q-1:0] en_q;
    logic [NUM_Q-1:0] clr_mask;
    logic [NUM_Q-1:0] drop_mask;
    logic [NUM_Q-1:0] gated_w;

    qsel_regs #(
        .NUM_Q(NUM_Q), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sel_o(sel_w), .en_o(en_q), .clr_mask_o(clr_mask), .drop_mask_o(drop_mask)
    );

    qsel_cond #(.NUM_Q(NUM_Q)) u_cond (
        .q_status(q_status), .sel(sel_w), .en(en_q), .gated_o(gated_w)
    );

    qsel_pend #(.NUM_Q(NUM_Q)) u_pend (
        .clk(clk), .rst(rst), .gated(gated_w), .clr_mask(clr_mask),
        .drop_mask(drop_mask), .pend_o(pending)
    );

    assign irq = |pending;

endmodule

// File: rtl/qstat_irq_sel_chk.sv
module qstat_irq_sel_chk #(
    parameter int unsigned NUM_Q   = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 3,
    parameter int unsigned FIELD_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [NUM_Q-1:0]  pending,
    input logic              irq,
    input logic [NUM_Q-1:0]  en_q,
    input logic [NUM_Q-1:0]  gated_w
);
    localparam int unsigned PER_REG = DATA_W / FIELD_W;
    localparam int unsigned ADR_EN  = NUM_Q / PER_REG;

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (pending == '0 && !irq));

    // R4
    a_r4_no_set_disabled: assert property (@(posedge clk) disable iff (rst)
        (pending & ~$past(pending) & ~$past(en_q)) == '0);

    // R5
    a_r5_set_needs_cond: assert property (@(posedge clk) disable iff (rst)
        (pending & ~$past(pending) & ~$past(gated_w)) == '0);

    // R7
    a_r7_no_fall_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (($past(pending) & ~pending) == '0));

    // R9
    a_r9_disable_drops: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(ADR_EN)) |=>
        ((pending & $past(en_q) & ~$past(wr_data[NUM_Q-1:0])) == '0));

endmodule

bind qstat_irq_sel qstat_irq_sel_chk #(
    .NUM_Q(NUM_Q), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pending(pending), .irq(irq), .en_q(en_q), .gated_w(gated_w)
);

// File: tb/qstat_irq_sel_bench.sv
`timescale 1ns/1ps
module qstat_irq_sel_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [127:0] q_status = '0;
    logic [31:0]  pending;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    qstat_irq_sel u_qstat_irq_sel (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .q_status(q_status), .pending(pending), .irq(irq)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic set_nib(input int q, input logic [3:0] v);
        q_status[q*4 +: 4] = v;
    endtask

    task automatic chk(input string req, input logic [31:0] exp);
        checks++;
        if (pending !== exp || irq !== (exp != 0)) begin
            fails++;
            $display("FAIL %s: pending=%h irq=%b expected pending=%h irq=%b",
                     req, pending, irq, exp, (exp != 0));
        end
    endtask

    task automatic t_reset();
        chk("R1 reset", 32'h0);
        q_status = {128{1'b1}};
        step(); step();
        chk("R4 disabled after reset", 32'h0);
        wr(3'd4, 32'h1);
        step();
        chk("R1 reset source code is empty", 32'h1);
        q_status = '0;
        wr(3'd4, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);
        chk("R7 clear all", 32'h0);
    endtask

    task automatic t_codes();
        for (int c = 0; c < 8; c++) begin
            logic [3:0] fnib;
            fnib = {4{c[2]}};
            set_nib(11, fnib);
            wr(3'd4, 32'h0);
            wr(3'd5, 32'hFFFF_FFFF);
            wr(3'd1, 32'(c) << 12);
            wr(3'd4, 32'h1 << 11);
            step();
            chk($sformatf("R2 code %0d false", c), 32'h0);
            set_nib(11, fnib ^ (4'h1 << c[1:0]));
            step();
            chk($sformatf("R2 R5 code %0d true", c), 32'h1 << 11);
        end
    endtask

    task automatic t_pack();
        q_status = '0;
        wr(3'd4, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h3 << 24);
        wr(3'd3, 32'hB << 24);
        wr(3'd4, 32'hFFFF_FFFF);
        step();
        chk("R3 all quiet", 32'h0);
        set_nib(30, 4'h8);
        step();
        chk("R3 queue 30 full", 32'h1 << 30);
        wr(3'd5, 32'h1 << 30);
        chk("R6 cleared", 32'h0);
        step(); step();
        chk("R6 held condition no re-set", 32'h0);
        set_nib(30, 4'h0);
        step();
        set_nib(30, 4'h8);
        step();
        chk("R6 new edge re-sets", 32'h1 << 30);
        wr(3'd5, 32'hFFFF_FFFF);
    endtask

    task automatic t_clear();
        set_nib(1, 4'h1); set_nib(2, 4'h1); set_nib(5, 4'h1);
        step();
        chk("R10 three pending", 32'h26);
        wr(3'd5, 32'h4);
        chk("R7 partial clear", 32'h22);
        wr(3'd5, 32'hFFFF_FFFF);
        chk("R7 full clear", 32'h0);
    endtask

    task automatic t_set_wins();
        set_nib(1, 4'h0);
        step();
        set_nib(1, 4'h1);
        step();
        chk("R5 queue 1 pending", 32'h2);
        set_nib(7, 4'h1);
        wr(3'd5, 32'hFFFF_FFFF);
        chk("R8 set beats clear", 32'h80);
    endtask

    task automatic t_disable();
        set_nib(7, 4'h0);
        step();
        chk("R9 before disable", 32'h80);
        set_nib(7, 4'h1);
        wr(3'd4, ~(32'h1 << 7));
        chk("R9 disable clears over set", 32'h0);
        step();
        chk("R9 stays clear", 32'h0);
    endtask

    task automatic t_ignored();
        set_nib(3, 4'h1);
        step();
        chk("R5 queue 3 pending", 32'h8);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        chk("R11 pending untouched", 32'h8);
        step();
        chk("R11 enables untouched", 32'h8);
        wr(3'd4, 32'hFFFF_FFFF);
        chk("R5 one cycle latency", 32'h8);
        step();
        chk("R5 enable while true", 32'h88);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_codes();
        t_pack();
        t_clear();
        t_set_wins();
        t_disable();
        t_ignored();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule